// File: doc/BRIEF.md
# Highway and Farm-Road Signal Controller

This block runs the lamps where a busy highway crosses a quiet farm road. The highway holds green until a car is detected on the farm road and the highway has also had a long minimum green. Each road then passes through a yellow phase before the other road gets green. The farm road keeps green only while cars keep arriving and the long interval has not run out.

A single interval timer serves every phase. The controller raises a one-cycle phase-start strobe at each transition. The strobe clears the timer, and the timer then reports when the short interval and the long interval have elapsed. The raw car sensor is asynchronous, so it passes through a synchroniser chain before the controller sees it.

Lamp outputs are decoded from the two-bit phase code alone. A parameter selects how the next-phase logic is built: as a case-coded state machine, or as a two-bit up-counter whose enable comes from a four-way multiplexer of advance conditions. Both builds behave the same at the ports.

Top module: `xroad_signal_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the phase code is 2'b00 (highway green), `phase_start` is low and both `short_up` and `long_up` are low.
- R2: In highway green (code 2'b00) the phase advances to highway yellow (code 2'b10) only when the synchronised car input and `long_up` are both high. A car without an expired long interval holds the phase.
- R3: In highway yellow the phase advances to farm green (code 2'b01) when `short_up` is high, whatever the car input is.
- R4: In farm green the phase advances to farm yellow (code 2'b11) when the synchronised car input is low or `long_up` is high.
- R5: In farm yellow the phase advances to highway green when `short_up` is high.
- R6: `phase_start` is high in exactly those cycles whose next clock edge changes the phase, and it depends on the current phase and the current inputs in that same cycle.
- R7: The interval count is zero in the cycle after `phase_start`, and then rises by one each cycle. `short_up` is high once the count reaches SHORT_CYC, so it is high in the SHORT_CYC-th cycle after a phase entry.
- R8: `long_up` is high once the count reaches LONG_CYC, which is greater than SHORT_CYC. The count saturates there, so `long_up` implies `short_up` and both stay high until the next `phase_start`.
- R9: A change on `car_raw` reaches the controller after SYNC_STAGES clock edges (2 by default). With the other conditions met, a car first asserted before edge k makes `phase_start` high after edge k+1, and not after edge k.
- R10: Lamps decode from the code alone. Bit 0 set gives the farm road right of way; bit 1 set means yellow. Exactly one highway lamp and exactly one farm lamp are lit, and at least one road shows red.
- R11: With COUNTER_FORM=1, the counter-and-multiplexer build produces the same phase code, `phase_start` and lamps as the case-coded build for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| car_raw | input | 1 | Asynchronous car-present sensor on the farm road |
| phase_code | output | 2 | Current phase: 00 hwy green, 10 hwy yellow, 01 farm green, 11 farm yellow |
| phase_start | output | 1 | Combinational strobe, high when the next edge changes phase |
| short_up | output | 1 | Short interval has elapsed since the last phase start |
| long_up | output | 1 | Long interval has elapsed since the last phase start |
| hw_green | output | 1 | Highway green lamp |
| hw_yellow | output | 1 | Highway yellow lamp |
| hw_red | output | 1 | Highway red lamp |
| fr_green | output | 1 | Farm-road green lamp |
| fr_yellow | output | 1 | Farm-road yellow lamp |
| fr_red | output | 1 | Farm-road red lamp |

## Verification
The main cycle is run with the car held present throughout. This separates farm green ending on the long interval from farm green ending on car absence. The car is then dropped during highway yellow and again partway through farm green, which shows that farm green exits early on car absence alone. A car that arrives before the long interval has expired must hold highway green until the timer saturates. A car applied for one edge against two must show the synchroniser latency. Every table step is compared against a second instance built in counter form, which checks that the two builds agree.

// File: rtl/xroad_pkg.sv
package xroad_pkg;
  // Phase codes: bit0 = farm road owns the crossing, bit1 = yellow warning
  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'b00,
    PH_HWY_WARN  = 2'b10,
    PH_FARM_GO   = 2'b01,
    PH_FARM_WARN = 2'b11
  } phase_e;
endpackage

// File: rtl/xroad_car_sync.sv
module xroad_car_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xroad_interval_timer.sv
module xroad_interval_timer #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_up,
  output logic long_up
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                count_q <= '0;
    else if (restart)          count_q <= '0;
    else if (count_q != LONG_V) count_q <= count_q + 1'b1;
  end

  assign short_up = (count_q >= SHORT_V);
  assign long_up  = (count_q >= LONG_V);

  initial begin
    if (LONG_CYC <= SHORT_CYC || SHORT_CYC < 1)
      $error("interval timer: need 1 <= SHORT_CYC < LONG_CYC");
  end

  p_clear_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0));
  p_long_implies_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    long_up |-> short_up);
  p_long_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (long_up && !restart) |=> long_up);
endmodule

// File: rtl/xroad_phase_ctrl.sv
module xroad_phase_ctrl
  import xroad_pkg::*;
#(
  parameter bit COUNTER_FORM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car,
  input  logic       short_up,
  input  logic       long_up,
  output logic [1:0] phase_code,
  output logic       phase_start
);
  generate
    if (COUNTER_FORM) begin : g_counter
      // step 0..3 walks HWY_GO, HWY_WARN, FARM_GO, FARM_WARN in order
      logic [1:0] step_q;
      logic [3:0] advance;
      assign advance     = {short_up, (long_up | ~car), short_up, (long_up & car)};
      assign phase_start = advance[step_q];
      assign phase_code  = {step_q[0], step_q[1]};
      always_ff @(posedge clk) begin
        if (!rst_n)           step_q <= 2'd0;
        else if (phase_start) step_q <= step_q + 2'd1;
      end
    end else begin : g_case
      phase_e state_q, state_d;
      logic   go;
      always_comb begin
        state_d = state_q;
        go      = 1'b0;
        unique case (state_q)
          PH_HWY_GO:    if (car && long_up)   begin go = 1'b1; state_d = PH_HWY_WARN;  end
          PH_HWY_WARN:  if (short_up)         begin go = 1'b1; state_d = PH_FARM_GO;   end
          PH_FARM_GO:   if (!car || long_up)  begin go = 1'b1; state_d = PH_FARM_WARN; end
          PH_FARM_WARN: if (short_up)         begin go = 1'b1; state_d = PH_HWY_GO;    end
          default:                            begin go = 1'b0; state_d = PH_HWY_GO;    end
        endcase
      end
      always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_HWY_GO;
        else        state_q <= state_d;
      end
      assign phase_code  = state_q;
      assign phase_start = go;
    end
  endgenerate

  p_start_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_start |=> (phase_code != $past(phase_code)));
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_start |=> (phase_code == $past(phase_code)));
  p_hwy_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code == 2'b00 && phase_start) |-> (car && long_up));
  p_warn_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code == 2'b10 && short_up) |=> (phase_code == 2'b01));
  p_farm_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code == 2'b01 && (!car || long_up)) |-> phase_start);
  p_farm_warn_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code == 2'b11 && phase_start) |=> (phase_code == 2'b00));
endmodule

// File: rtl/xroad_lamp_decode.sv
module xroad_lamp_decode (
  input  logic [1:0] phase_code,
  output logic       hw_green,
  output logic       hw_yellow,
  output logic       hw_red,
  output logic       fr_green,
  output logic       fr_yellow,
  output logic       fr_red
);
  logic farm_owns, warn;
  assign farm_owns = phase_code[0];
  assign warn      = phase_code[1];

  assign hw_green  = ~farm_owns & ~warn;
  assign hw_yellow = ~farm_owns &  warn;
  assign hw_red    =  farm_owns;
  assign fr_green  =  farm_owns & ~warn;
  assign fr_yellow =  farm_owns &  warn;
  assign fr_red    = ~farm_owns;
endmodule

// File: rtl/xroad_signal_top.sv
module xroad_signal_top #(
  parameter int SHORT_CYC    = 3,
  parameter int LONG_CYC     = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit COUNTER_FORM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_raw,
  output logic [1:0] phase_code,
  output logic       phase_start,
  output logic       short_up,
  output logic       long_up,
  output logic       hw_green,
  output logic       hw_yellow,
  output logic       hw_red,
  output logic       fr_green,
  output logic       fr_yellow,
  output logic       fr_red
);
  logic car_s;

  xroad_car_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(car_raw), .dout(car_s)
  );

  xroad_interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(phase_start),
    .short_up(short_up), .long_up(long_up)
  );

  xroad_phase_ctrl #(.COUNTER_FORM(COUNTER_FORM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .car(car_s),
    .short_up(short_up), .long_up(long_up),
    .phase_code(phase_code), .phase_start(phase_start)
  );

  xroad_lamp_decode u_lamps (
    .phase_code(phase_code),
    .hw_green(hw_green), .hw_yellow(hw_yellow), .hw_red(hw_red),
    .fr_green(fr_green), .fr_yellow(fr_yellow), .fr_red(fr_red)
  );

  p_one_hwy_lamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hw_green, hw_yellow, hw_red}) == 1);
  p_one_farm_lamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fr_green, fr_yellow, fr_red}) == 1);
  p_some_red_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_red || fr_red));
  p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code == 2'b00 && phase_start) |-> $past(car_raw, 2));
endmodule

// File: tb/xroad_signal_top_tb.sv
module xroad_signal_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_raw = 1'b0;
  logic [1:0] code_a, code_b;
  logic st_a, st_b, ts_a, tl_a, ts_b, tl_b;
  logic [5:0] lamps_a, lamps_b;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xroad_signal_top #(.SHORT_CYC(3), .LONG_CYC(8), .SYNC_STAGES(2), .COUNTER_FORM(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .car_raw(car_raw),
    .phase_code(code_a), .phase_start(st_a), .short_up(ts_a), .long_up(tl_a),
    .hw_green(lamps_a[5]), .hw_yellow(lamps_a[4]), .hw_red(lamps_a[3]),
    .fr_green(lamps_a[2]), .fr_yellow(lamps_a[1]), .fr_red(lamps_a[0])
  );

  xroad_signal_top #(.SHORT_CYC(3), .LONG_CYC(8), .SYNC_STAGES(2), .COUNTER_FORM(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .car_raw(car_raw),
    .phase_code(code_b), .phase_start(st_b), .short_up(ts_b), .long_up(tl_b),
    .hw_green(lamps_b[5]), .hw_yellow(lamps_b[4]), .hw_red(lamps_b[3]),
    .fr_green(lamps_b[2]), .fr_yellow(lamps_b[1]), .fr_red(lamps_b[0])
  );

  typedef struct packed {
    logic       car;
    logic [7:0] n;
    logic [1:0] ph;
    logic       st;
    logic       ts;
    logic       tl;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd20, 2'b00, 1'b0, 1'b1, 1'b1},  // idle highway, timer saturated
    '{1'b1, 8'd1,  2'b00, 1'b0, 1'b1, 1'b1},  // R9: car not yet through sync
    '{1'b1, 8'd1,  2'b00, 1'b1, 1'b1, 1'b1},  // R9: visible after 2nd edge
    '{1'b1, 8'd1,  2'b10, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd3,  2'b10, 1'b1, 1'b1, 1'b0},
    '{1'b1, 8'd1,  2'b01, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd8,  2'b01, 1'b1, 1'b1, 1'b1},  // farm green ends on long
    '{1'b1, 8'd1,  2'b11, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd3,  2'b11, 1'b1, 1'b1, 1'b0},
    '{1'b1, 8'd1,  2'b00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd8,  2'b00, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'd1,  2'b10, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd4,  2'b01, 1'b1, 1'b0, 1'b0},  // no car on farm green entry
    '{1'b0, 8'd1,  2'b11, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd4,  2'b00, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd30, 2'b00, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'd10, 2'b01, 1'b0, 1'b1, 1'b0},
    '{1'b0, 8'd2,  2'b01, 1'b1, 1'b1, 1'b0},  // car leaves mid farm green
    '{1'b0, 8'd1,  2'b11, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd3,  2'b11, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'd1,  2'b00, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [5:0] lamps_for(input logic [1:0] ph);
    case (ph)
      2'b00:   return 6'b100_001;
      2'b10:   return 6'b010_001;
      2'b01:   return 6'b001_100;
      default: return 6'b001_010;
    endcase
  endfunction

  function automatic string phase_req(input logic [1:0] ph);
    case (ph)
      2'b00:   return "R2";
      2'b10:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic car, input int n);
    @(negedge clk);
    car_raw = car;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: state during reset
    repeat (3) @(posedge clk);
    #2;
    chk(code_a == 2'b00, "R1", "phase in reset", code_a, 0);
    chk(!st_a && !ts_a && !tl_a, "R1", "start/short/long in reset", {st_a, ts_a, tl_a}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk(code_a == 2'b00 && !ts_a && !tl_a, "R1", "first cycle after reset",
        {code_a, ts_a, tl_a}, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].car, int'(VEC[i].n));
      chk(code_a == VEC[i].ph, phase_req(VEC[i].ph), $sformatf("phase step %0d", i),
          code_a, VEC[i].ph);
      chk(st_a == VEC[i].st, (i == 1 || i == 2) ? "R9" : "R6",
          $sformatf("phase_start step %0d", i), st_a, VEC[i].st);
      chk(ts_a == VEC[i].ts, "R7", $sformatf("short_up step %0d", i), ts_a, VEC[i].ts);
      chk(tl_a == VEC[i].tl, "R8", $sformatf("long_up step %0d", i), tl_a, VEC[i].tl);
      chk(lamps_a == lamps_for(VEC[i].ph), "R10", $sformatf("lamps step %0d", i),
          lamps_a, lamps_for(VEC[i].ph));
      chk(code_b == code_a && st_b == st_a && lamps_b == lamps_a, "R11",
          $sformatf("counter form step %0d", i), {code_b, st_b, lamps_b},
          {code_a, st_a, lamps_a});
    end

    // R2: car present but long interval not yet over holds highway green
    step(1'b1, 3);
    chk(code_a == 2'b00 && !st_a, "R2", "car before long interval", {code_a, st_a}, 0);
    step(1'b1, 5);
    chk(st_a && tl_a, "R2", "advance once long interval over", {st_a, tl_a}, 3);
    step(1'b1, 1);
    chk(code_a == 2'b10, "R2", "entered highway yellow", code_a, 2);
    chk(code_b == 2'b10, "R11", "counter form yellow", code_b, 2);

    // R1: reset in mid-run returns to highway green with timer cleared
    step(1'b1, 2);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    chk(code_a == 2'b00 && !st_a && !ts_a && !tl_a, "R1", "mid-run reset",
        {code_a, st_a, ts_a, tl_a}, 0);
    chk(lamps_a == 6'b100_001, "R10", "lamps after reset", lamps_a, 6'b100_001);
    finish_run();
  end
endmodule